// File: doc/BRIEF.md
# Per-Channel PCM Code Translator

This block converts one 8-bit PCM channel byte from one coding to another as the byte leaves a time-slot switch. Each output channel's control word sets three things: a voice/data select, a 2-bit input code and a 2-bit output code. In voice mode the codes select among four companding laws. These are two A-law forms and two µ-law forms, and each family has a form with its usual line inversion and a form without it. In data mode the codes select one of four fixed XOR masks.

Voice translation works in three steps. The incoming byte is first reduced to a canonical sign/segment/mantissa word for its family. If the families differ, the word is re-encoded through a 16-bit linear magnitude. Finally the inversion of the output form is applied. The result is registered, so the translated byte and its strobe appear one clock after the input strobe.

Top module: `pcm_xlat`

## Requirements
- R1: While rst_ni is low, and until the first captured byte, valid_o is 0 and data_o is 8'h00.
- R2: valid_o equals valid_i delayed by one clock. data_o is loaded only on a clock edge where valid_i is 1, and otherwise holds its value.
- R3: If in_code_i equals out_code_i, data_o equals the captured data_i in both modes.
- R4: With is_data_i = 1, the code masks are 00 = 8'h00, 01 = 8'h55 (bits 6,4,2,0), 10 = 8'hAA (bits 7,5,3,1) and 11 = 8'hFF. The output equals input ^ mask(in_code_i) ^ mask(out_code_i).
- R5: With is_data_i = 0, code 00 is standard A-law (line = canonical ^ 8'h55) and code 10 is A-law with no even-bit inversion (line = canonical). Translation between 00 and 10 is therefore XOR 8'h55.
- R6: With is_data_i = 0, code 01 is standard µ-law (line = canonical ^ 8'h7F) and code 11 is µ-law with no magnitude inversion (line = canonical). Translation between 01 and 11 is therefore XOR 8'h7F.
- R7: The canonical word is {pos, seg[2:0], mant[3:0]}, where pos = 1 means positive. For A-law to µ-law, the A-law magnitude is expanded to 16 bits as mant*16+8 for seg 0 and (mant*16+264)<<(seg-1) otherwise. It is then re-encoded to µ-law by truncation: v = mag+132, seg = position of the top bit of v minus 7, mant = (v>>(seg+3)) & 15. The sign is kept.
- R8: For µ-law to A-law, the µ-law magnitude is expanded as ((mant*8+132)<<seg) - 132. It is then re-encoded to A-law by truncation: seg 0 if mag < 256, else seg = top bit position minus 7, and mant = mag>>4 for seg 0 or (mag>>(seg+3)) & 15 otherwise. The sign is kept.
- R9: Full scale maps to full scale: µ-law 8'h80 maps to A-law 8'hAA, µ-law 8'h00 to 8'h2A, and the reverse conversions do the same. Positive zero µ-law 8'hFF maps to A-law 8'hD5.
- R10: is_data_i selects the path. The same byte and codes give the data-mask result when it is 1 and the companding result when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input byte strobe |
| data_i | input | 8 | Input channel byte |
| is_data_i | input | 1 | 1 = data masks, 0 = voice laws |
| in_code_i | input | 2 | Coding of data_i |
| out_code_i | input | 2 | Coding wanted on data_o |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |
| data_o | output | 8 | Translated byte |

## Verification
Every result is due exactly one clock after the edge that captures it. The bench changes the inputs on a falling edge, the rising edge captures them, and data_o and valid_o are compared on the next falling edge. The hold check holds valid_i low for a cycle and confirms at that falling edge that data_o has kept the previous result and that valid_o has dropped. The cross-family results come from an arithmetic model in the bench, which uses multiplication and threshold search. This model is tried on all 256 bytes for every family-crossing code pair.

// File: rtl/pcm_xlat_pkg.sv
package pcm_xlat_pkg;
  localparam int BYTE_W = 8;
  localparam int LIN_W  = 16;

  typedef struct packed {
    logic       pos;
    logic [2:0] seg;
    logic [3:0] mant;
  } pcm_word_t;

  // canonical = line ^ mask; bit 0 of the code selects the mu family
  function automatic logic [BYTE_W-1:0] voice_mask(input logic [1:0] code);
    case (code)
      2'b00:   return 8'h55;
      2'b01:   return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] data_mask(input logic [1:0] code);
    case (code)
      2'b00:   return 8'h00;
      2'b01:   return 8'h55;
      2'b10:   return 8'hAA;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/pcm_law_conv.sv
module pcm_law_conv
  import pcm_xlat_pkg::*;
#(
  parameter bit TO_MU = 1'b1,
  parameter int LW    = LIN_W
) (
  input  pcm_word_t in_w,
  output pcm_word_t out_w
);
  localparam int TOP = LW - 2;
  localparam logic [LW-1:0] MU_BIAS = LW'(132);

  logic [LW-1:0] mag;
  logic [LW-1:0] enc_v;
  logic [3:0]    top_bit;
  logic [2:0]    seg_o;
  logic [3:0]    mant_o;

  generate
    if (TO_MU) begin : g_a2u
      logic [LW-1:0] base;
      always_comb begin
        base = LW'({in_w.mant, 4'h8});
        if (in_w.seg == 3'd0) mag = base;
        else                  mag = (base + LW'(256)) << (in_w.seg - 3'd1);
        enc_v = mag + MU_BIAS;
      end
    end else begin : g_u2a
      always_comb begin
        mag   = ((LW'({in_w.mant, 3'b100}) + LW'(128)) << in_w.seg) - MU_BIAS;
        enc_v = mag;
      end
    end
  endgenerate

  always_comb begin
    top_bit = 4'd7;
    for (int p = 8; p <= TOP; p++) begin
      if (enc_v[p]) top_bit = 4'(p);
    end
    seg_o  = 3'(top_bit - 4'd7);
    mant_o = 4'(enc_v >> (top_bit - 4'd4));
    if (!TO_MU && top_bit == 4'd7) mant_o = enc_v[7:4];
    out_w = '{pos: in_w.pos, seg: seg_o, mant: mant_o};
  end
endmodule

// File: rtl/pcm_voice_xlat.sv
module pcm_voice_xlat
  import pcm_xlat_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        in_code_i,
  input  logic [1:0]        out_code_i,
  output logic [BYTE_W-1:0] data_o
);
  pcm_word_t w_in, w_a2u, w_u2a, w_sel;

  assign w_in = pcm_word_t'(data_i ^ voice_mask(in_code_i));

  pcm_law_conv #(.TO_MU(1'b1), .LW(LIN_W)) i_a2u (.in_w(w_in), .out_w(w_a2u));
  pcm_law_conv #(.TO_MU(1'b0), .LW(LIN_W)) i_u2a (.in_w(w_in), .out_w(w_u2a));

  always_comb begin
    if (in_code_i[0] == out_code_i[0]) w_sel = w_in;
    else if (!in_code_i[0])            w_sel = w_a2u;
    else                               w_sel = w_u2a;
  end

  assign data_o = w_sel ^ voice_mask(out_code_i);
endmodule

// File: rtl/pcm_data_xlat.sv
module pcm_data_xlat
  import pcm_xlat_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  input  logic [1:0]        in_code_i,
  input  logic [1:0]        out_code_i,
  output logic [BYTE_W-1:0] data_o
);
  assign data_o = data_i ^ data_mask(in_code_i) ^ data_mask(out_code_i);
endmodule

// File: rtl/pcm_xlat.sv
module pcm_xlat
  import pcm_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              is_data_i,
  input  logic [1:0]        in_code_i,
  input  logic [1:0]        out_code_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] voice_q, data_q, next_byte;

  pcm_voice_xlat i_voice (
    .data_i(data_i), .in_code_i(in_code_i), .out_code_i(out_code_i), .data_o(voice_q)
  );
  pcm_data_xlat i_data (
    .data_i(data_i), .in_code_i(in_code_i), .out_code_i(out_code_i), .data_o(data_q)
  );

  assign next_byte = is_data_i ? data_q : voice_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= next_byte;
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));
  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // R3
  same_code_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && in_code_i == out_code_i |=> data_o == $past(data_i));
  // R4
  all_invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_data_i && in_code_i == 2'b00 && out_code_i == 2'b11 |=> data_o == ~$past(data_i));
  // R5
  a_variant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_data_i && in_code_i == 2'b00 && out_code_i == 2'b10 |=> data_o == ($past(data_i) ^ 8'h55));
  // R6
  u_variant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_data_i && in_code_i == 2'b01 && out_code_i == 2'b11 |=> data_o == ($past(data_i) ^ 8'h7F));
  // R7
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_data_i && in_code_i == 2'b10 && out_code_i == 2'b11 |=> data_o[7] == $past(data_i[7]));
endmodule

// File: tb/test_pcm_xlat.sv
module test_pcm_xlat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       is_data_i = 1'b0;
  logic [1:0] in_code_i = 2'b00, out_code_i = 2'b00;
  logic       valid_o;
  logic [7:0] data_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcm_xlat i_pcm_xlat (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .is_data_i(is_data_i), .in_code_i(in_code_i), .out_code_i(out_code_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  // ---------- reference model from the requirements ----------
  function automatic int dmask(input logic [1:0] c);
    int t[4] = '{0, 'h55, 'hAA, 'hFF};
    return t[c];
  endfunction
  function automatic int vmask(input logic [1:0] c);
    return (c == 2'b00) ? 'h55 : (c == 2'b01) ? 'h7F : 0;
  endfunction
  function automatic int a_lin(input int s, input int m);
    return (s == 0) ? m * 16 + 8 : (m * 16 + 264) * (1 << (s - 1));
  endfunction
  function automatic int u_lin(input int s, input int m);
    return (m * 8 + 132) * (1 << s) - 132;
  endfunction
  function automatic int a_enc(input int mag);
    int s = 0;
    for (int k = 1; k < 8; k++) if (mag >= (256 << (k - 1))) s = k;
    return (s == 0) ? (mag / 16) : (s * 16 + ((mag >> (s + 3)) & 15));
  endfunction
  function automatic int u_enc(input int mag);
    int v = mag + 132;
    int s = 0;
    for (int k = 1; k < 8; k++) if (v >= (128 << k)) s = k;
    return s * 16 + ((v >> (s + 3)) & 15);
  endfunction
  function automatic logic [7:0] ref_out(input logic [7:0] d, input logic isd,
                                         input logic [1:0] ic, input logic [1:0] oc);
    int c, sgn, s, m, r;
    if (isd) return 8'(int'(d) ^ dmask(ic) ^ dmask(oc));
    c = int'(d) ^ vmask(ic);
    sgn = c & 'h80; s = (c >> 4) & 7; m = c & 15;
    if (ic[0] == oc[0])  r = c;
    else if (!ic[0])     r = sgn | u_enc(a_lin(s, m));
    else                 r = sgn | a_enc(u_lin(s, m));
    return 8'(r ^ vmask(oc));
  endfunction

  // ---------- helpers ----------
  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input string req, input logic [7:0] d, input logic isd,
                      input logic [1:0] ic, input logic [1:0] oc, input logic [7:0] exp);
    @(negedge clk);
    valid_i = 1'b1; data_i = d; is_data_i = isd; in_code_i = ic; out_code_i = oc;
    @(negedge clk);
    check(req, data_o, exp);
    check({req, " valid"}, {7'd0, valid_o}, 8'd1);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset;
    #1;
    check("R1 data", data_o, 8'h00);
    check("R1 valid", {7'd0, valid_o}, 8'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", data_o, 8'h00);
  endtask

  task automatic t_hold;
    xfer("R2 load", 8'h3C, 1'b1, 2'b00, 2'b11, 8'hC3);
    @(negedge clk);
    valid_i = 1'b0; data_i = 8'h11; in_code_i = 2'b00; out_code_i = 2'b00;
    @(negedge clk);
    check("R2 hold data", data_o, 8'hC3);
    check("R2 valid low", {7'd0, valid_o}, 8'd0);
  endtask

  task automatic t_pass;
    for (int c = 0; c < 4; c++)
      for (int md = 0; md < 2; md++)
        xfer("R3", 8'(37 * c + 91 * md + 5), md[0], 2'(c), 2'(c), 8'(37 * c + 91 * md + 5));
  endtask

  task automatic t_data;
    logic [7:0] pats[4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 16; c++)
        xfer("R4", pats[i], 1'b1, 2'(c >> 2), 2'(c), ref_out(pats[i], 1'b1, 2'(c >> 2), 2'(c)));
    xfer("R4 odd mask", 8'h00, 1'b1, 2'b00, 2'b10, 8'hAA);
    xfer("R4 even mask", 8'h00, 1'b1, 2'b01, 2'b00, 8'h55);
  endtask

  task automatic t_variants;
    xfer("R5 A std->raw", 8'hD5, 1'b0, 2'b00, 2'b10, 8'h80);
    xfer("R5 A raw->std", 8'h12, 1'b0, 2'b10, 2'b00, 8'h47);
    xfer("R6 u std->raw", 8'hFF, 1'b0, 2'b01, 2'b11, 8'h80);
    xfer("R6 u raw->std", 8'h05, 1'b0, 2'b11, 2'b01, 8'h7A);
  endtask

  task automatic t_cross;
    for (int c = 0; c < 16; c++) begin
      if ((c >> 2) % 2 == c % 2) continue;
      for (int b = 0; b < 256; b++)
        xfer(((c >> 2) % 2 == 0) ? "R7" : "R8", 8'(b), 1'b0, 2'(c >> 2), 2'(c),
             ref_out(8'(b), 1'b0, 2'(c >> 2), 2'(c)));
    end
  endtask

  task automatic t_bounds;
    xfer("R9 u+max->A", 8'h80, 1'b0, 2'b01, 2'b00, 8'hAA);
    xfer("R9 u-max->A", 8'h00, 1'b0, 2'b01, 2'b00, 8'h2A);
    xfer("R9 A+max->u", 8'hAA, 1'b0, 2'b00, 2'b01, 8'h80);
    xfer("R9 A-max->u", 8'h2A, 1'b0, 2'b00, 2'b01, 8'h00);
    xfer("R9 u+0->A", 8'hFF, 1'b0, 2'b01, 2'b00, 8'hD5);
  endtask

  task automatic t_mode_sel;
    xfer("R10 data", 8'h80, 1'b1, 2'b01, 2'b00, 8'hD5);
    xfer("R10 voice", 8'h80, 1'b0, 2'b01, 2'b00, 8'hAA);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_pass();
    t_data();
    t_variants();
    t_cross();
    t_bounds();
    t_mode_sel();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule